// File: doc/BRIEF.md
# Page Access Permission Checker

This block judges one page-table entry during address translation. It takes the entry's attribute bits and a description of the access, and decides whether the access must raise a page fault. The attribute bits are present, writable, user-accessible and a field of reserved bits. The access is described by its type (read or write), the current privilege mode and two control flags. One flag turns on write protection for supervisor code. The other, an extended-mode flag, makes the reserved bits subject to checking. The decision is a fault flag and a 4-bit error code, which the fault handler uses to find out why the access was refused.

A request is presented with a one-cycle valid strobe. One clock later the registered verdict appears, together with a one-cycle done pulse. The verdict then holds until the next strobe. The table walk, translation caching and address arithmetic live elsewhere. This block only turns one entry and one access into a verdict.

Top module: `page_perm_check`

## Requirements
- R1: After reset, fault, err_code and done are all 0.
- R2: done is 1 in exactly the cycle after each cycle in which chk_valid is 1, and 0 otherwise; fault and err_code take the new verdict in that same cycle.
- R3: An entry with pte_present=0 always faults. err_code bit 0 is then 0 and bit 3 is 0, whatever the other entry bits and flags are.
- R4: A user-mode access (mode_user=1) to an entry with pte_user=0 faults, for reads and for writes.
- R5: A user-mode write to an entry with pte_writable=0 faults. A user-mode read of a present, user-accessible, read-only entry does not fault when no reserved-bit fault applies.
- R6: A supervisor-mode write (mode_user=0) to an entry with pte_writable=0 faults if and only if wp_en=1, for user and supervisor entries alike. Supervisor reads of present entries never fault unless a reserved-bit fault applies.
- R7: With ext_en=1, a present entry with any pte_rsvd bit at 1 faults, and err_code bit 3 is 1. With ext_en=0, pte_rsvd has no effect on the verdict.
- R8: err_code layout: bit 0 is 1 for a protection or reserved-bit fault and 0 for not-present; bit 1 is 1 for a write access; bit 2 is 1 for a user-mode access; bit 3 is the reserved-bit flag. When fault is 0, err_code is 0000.
- R9: Without a valid strobe, fault and err_code keep their last values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | One-cycle request strobe |
| pte_present | input | 1 | Entry present bit |
| pte_writable | input | 1 | Entry writable bit |
| pte_user | input | 1 | Entry user-accessible bit |
| pte_rsvd | input | RSVD_W | Entry reserved-bit field |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| mode_user | input | 1 | 1 when the access is made in user mode |
| wp_en | input | 1 | Enables write protection for supervisor writes |
| ext_en | input | 1 | Enables reserved-bit checking |
| fault | output | 1 | Registered fault verdict |
| err_code | output | 4 | Registered error code |
| done | output | 1 | One-cycle pulse marking a new verdict |

## Verification
The hardest case to reach is an entry that breaks several rules at once. Examples are a not-present entry that also has reserved bits set under extended mode, or a user write to a read-only supervisor page. In these cases precedence decides the code bits, and a random draw rarely lines up all the needed flags. The bench therefore adds directed cases that stack the violations on purpose. It also draws random vectors in which each attribute bit is biased, so that every combination of present, writable, user, mode, write protection and reserved bits is visited many times. Between strobes it scrambles the inputs with valid low, to show that the held verdict does not move.

// File: rtl/page_perm_check.sv
module page_perm_check #(
  parameter int RSVD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic              pte_present,
  input  logic              pte_writable,
  input  logic              pte_user,
  input  logic [RSVD_W-1:0] pte_rsvd,
  input  logic              acc_write,
  input  logic              mode_user,
  input  logic              wp_en,
  input  logic              ext_en,
  output logic              fault,
  output logic [3:0]        err_code,
  output logic              done
);

  logic not_present, priv_viol, ro_viol, rsvd_viol, any_fault;
  logic [3:0] code_next;

  assign not_present = !pte_present;
  assign priv_viol   = mode_user && !pte_user;
  assign ro_viol     = acc_write && !pte_writable && (mode_user || wp_en);
  assign rsvd_viol   = ext_en && (|pte_rsvd);
  assign any_fault   = not_present || priv_viol || ro_viol || rsvd_viol;

  always_comb begin
    code_next = 4'b0000;
    if (any_fault) begin
      code_next[0] = pte_present;
      code_next[1] = acc_write;
      code_next[2] = mode_user;
      code_next[3] = pte_present && rsvd_viol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault    <= 1'b0;
      err_code <= 4'b0000;
      done     <= 1'b0;
    end else begin
      done <= chk_valid;
      if (chk_valid) begin
        fault    <= any_fault;
        err_code <= code_next;
      end
    end
  end

  a_r2_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> done);

  a_r2_done_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !done);

  a_r3_not_present_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !pte_present) |=> (fault && !err_code[0] && !err_code[3]));

  a_r7_rsvd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && pte_present && ext_en && (|pte_rsvd)) |=> (fault && err_code[3] && err_code[0]));

  a_r8_clean_code: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (err_code == 4'b0000));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> ($stable(fault) && $stable(err_code)));

endmodule

// File: tb/tb_page_perm_check.sv
module tb_page_perm_check;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_valid = 1'b0;
  logic pte_present = 1'b0, pte_writable = 1'b0, pte_user = 1'b0;
  logic [RW-1:0] pte_rsvd = '0;
  logic acc_write = 1'b0, mode_user = 1'b0, wp_en = 1'b0, ext_en = 1'b0;
  logic fault, done;
  logic [3:0] err_code;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  page_perm_check #(.RSVD_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
    .pte_present(pte_present), .pte_writable(pte_writable), .pte_user(pte_user),
    .pte_rsvd(pte_rsvd), .acc_write(acc_write), .mode_user(mode_user),
    .wp_en(wp_en), .ext_en(ext_en),
    .fault(fault), .err_code(err_code), .done(done));

  function automatic logic [4:0] model(input logic p, input logic w, input logic u,
                                       input logic [RW-1:0] rs, input logic wr,
                                       input logic um, input logic wp, input logic ex);
    logic f, rv;
    logic [3:0] c;
    rv = ex && (rs != '0);
    f  = !p || (um && !u) || (wr && !w && (um || wp)) || rv;
    c  = 4'b0000;
    if (f) c = {p && rv, um, wr, p};
    return {f, c};
  endfunction

  function automatic string tag_of(input logic p, input logic w, input logic u,
                                   input logic [RW-1:0] rs, input logic wr,
                                   input logic um, input logic ex);
    if (!p) return "R3";
    if (ex && rs != '0) return "R7";
    if (um && !u) return "R4";
    if (um && wr && !w) return "R5";
    if (wr && !w) return "R6";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run(input logic p, input logic w, input logic u, input logic [RW-1:0] rs,
                     input logic wr, input logic um, input logic wp, input logic ex,
                     input string req);
    logic [4:0] exp;
    @(negedge clk);
    pte_present = p; pte_writable = w; pte_user = u; pte_rsvd = rs;
    acc_write = wr; mode_user = um; wp_en = wp; ext_en = ex; chk_valid = 1'b1;
    exp = model(p, w, u, rs, wr, um, wp, ex);
    @(negedge clk);
    chk_valid = 1'b0;
    check("R2", {4'b0000, done}, 5'b00001);
    check(req, {fault, err_code}, exp);
  endtask

  task automatic idle_scramble();
    logic [4:0] held;
    held = {fault, err_code};
    pte_present = 1'($urandom); pte_writable = 1'($urandom); pte_user = 1'($urandom);
    pte_rsvd = RW'($urandom); acc_write = 1'($urandom); mode_user = 1'($urandom);
    wp_en = 1'($urandom); ext_en = 1'($urandom);
    @(negedge clk);
    check("R9", {fault, err_code}, held);
    check("R2", {4'b0000, done}, 5'b00000);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12 rst_n = 1'b1;
    @(negedge clk);
    check("R1", {fault, err_code}, 5'b00000);
    check("R1", {4'b0000, done}, 5'b00000);

    run(0, 1, 1, 4'hF, 1, 1, 1, 1, "R3");
    run(0, 0, 0, 4'h0, 0, 0, 0, 0, "R3");
    run(1, 1, 0, 4'h0, 0, 1, 0, 0, "R4");
    run(1, 1, 0, 4'h0, 1, 1, 0, 0, "R4");
    run(1, 0, 1, 4'h0, 1, 1, 0, 0, "R5");
    run(1, 0, 1, 4'h0, 0, 1, 0, 0, "R5");
    run(1, 0, 1, 4'h0, 1, 0, 0, 0, "R6");
    run(1, 0, 1, 4'h0, 1, 0, 1, 0, "R6");
    run(1, 0, 0, 4'h0, 1, 0, 1, 0, "R6");
    run(1, 0, 0, 4'h0, 0, 0, 1, 0, "R6");
    run(1, 1, 1, 4'h8, 0, 0, 0, 1, "R7");
    run(1, 1, 1, 4'h8, 0, 0, 0, 0, "R7");
    run(1, 0, 0, 4'h1, 1, 1, 1, 1, "R7");
    run(1, 1, 1, 4'h0, 1, 1, 1, 1, "R8");
    idle_scramble();

    for (int i = 0; i < 1500; i++) begin
      logic p, w, u, wr, um, wp, ex;
      logic [RW-1:0] rs;
      p  = ($urandom % 8) != 0;
      w  = 1'($urandom); u = 1'($urandom); wr = 1'($urandom);
      um = 1'($urandom); wp = 1'($urandom); ex = 1'($urandom);
      rs = (($urandom % 3) == 0) ? RW'($urandom) : '0;
      run(p, w, u, rs, wr, um, wp, ex, tag_of(p, w, u, rs, wr, um, ex));
      if (($urandom % 4) == 0) idle_scramble();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule